// File: doc/BRIEF.md
# Latched Serial LED Sink Controller with Open-LED Readback

This block is the digital core of a serial-fed LED sink driver with `N` outputs (16 by default). A host shifts one bit per rising clock edge into a shift register. It moves data into a bank of output latches with the latch-enable pin and gates the sink drivers with an active-low output enable. The last register stage is the serial output, so several blocks can be chained by wiring each serial output to the next serial input. Analog sinks, comparators and the current reference sit outside. The block receives their results as digital flags: one comparator flag per output, a thermal-shutdown flag and a power-good flag.

A second mode is reached without extra pins. The block watches the pair (output enable, latch enable) on every clock edge. A fixed five-step pattern toggles it between normal mode and open-LED detection mode. In detection mode, holding output enable low for three or more edges and then raising it copies one error bit per output into the shift register, and the host shifts these bits out on the serial output, highest output first. The serial pins carry no back-pressure. Every clock edge moves exactly one bit, and the host paces the transfer by choosing when to clock.

Top module: `led_sink_ctl`

## Requirements
- R1: On each rising clock edge the register takes `sdi` into bit 0 and moves every bit one place up; `sdo` is bit N-1, so a word sent MSB first appears at `sdo` MSB first N edges later.
- R2: On each edge where `le` is high, the latches take the value the register holds after that edge, so with `le` held high the outputs follow the register every edge. While `le` is low the latches hold.
- R3: While `oe_n` is high every `sink_on` bit is 0, and the latch contents are unchanged: they reappear once `oe_n` is low again.
- R4: While `pwr_ok` is low the register, the latches and the sequencers are cleared to 0, and the block resumes in normal mode.
- R5: The mode toggles on the fifth edge of the sequence (`oe_n`,`le`) = (1,0), (0,0), (1,0), (1,1), (1,0). The same sequence both enters and leaves detection mode, and any other pair restarts the count at step 1, or at step 0 if that pair is not step 1.
- R6: After three steps of the sequence have matched, `le` is ignored on the next edge, so the latch-enable step of the sequence never loads the latches.
- R7: In detection mode, an edge with `oe_n` high that follows three or more consecutive edges with `oe_n` low loads the error bits into the register in place of a shift.
- R8: The error bit of output i is 1 only if its latch bit is 1 and `cmp_ok[i]` (1 = sink voltage at or above the open threshold) is 1 at the last low edge; otherwise it is 0.
- R9: After a capture, `sdo` presents the error bit of output N-1 at once, then N-2 and lower on following edges.
- R10: If `oe_n` returns high after fewer than three low edges, no capture happens and the register simply shifts.
- R11: While `tsd` is high all `sink_on` bits are 0. In normal mode the register and latches keep their data.
- R12: In detection mode, an edge with `tsd` high clears every register bit to 0.
- R13: In detection mode, new patterns are shifted and latched exactly as in normal mode, and later captures test the new pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial shift clock, rising edge active |
| pwr_ok | input | 1 | Power-good flag; low clears all state (asynchronous) |
| sdi | input | 1 | Serial data in |
| le | input | 1 | Latch enable, active high |
| oe_n | input | 1 | Output enable, active low |
| tsd | input | 1 | Thermal-shutdown flag |
| cmp_ok | input | N | Per-output comparator flag, 1 = not open |
| sdo | output | 1 | Serial data out / error readout |
| sink_on | output | N | Per-output sink drive command |

## Verification
`sink_on` is a combinational gate of the latches with `oe_n` and `tsd`, so a change of enable or shutdown is visible in the same cycle. A change of latch contents is visible right after the edge where `le` is high. Register and mode effects need one edge. The pattern or error bit loaded at edge k appears at `sdo` immediately after k, and bit j of it appears N-1-j edges later. The bench drives all inputs just after a falling edge and reads `sdo` and `sink_on` just before it drives again. Each readout bit is therefore taken at the position these counts predict.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

  typedef struct packed {
    logic oe_n;
    logic le;
  } pin_pair_t;

  // Number of clock-sampled steps that toggle the mode.
  localparam int SEQ_LEN = 5;

  // Pin pair expected at each step of the mode-toggle sequence.
  function automatic pin_pair_t seq_step(input int unsigned idx);
    pin_pair_t p;
    case (idx)
      0: p = '{oe_n: 1'b1, le: 1'b0};
      1: p = '{oe_n: 1'b0, le: 1'b0};
      2: p = '{oe_n: 1'b1, le: 1'b0};
      3: p = '{oe_n: 1'b1, le: 1'b1};
      default: p = '{oe_n: 1'b1, le: 1'b0};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/lsd_mode_seq.sv
module lsd_mode_seq
  import lsd_pkg::*;
#(
  parameter int CAP_MIN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oe_n,
  input  logic le,
  output logic det_mode,
  output logic le_block,
  output logic cap_fire,
  output logic cap_snap
);
  localparam int SW = $clog2(SEQ_LEN + 1);
  localparam int CW = $clog2(CAP_MIN + 1);
  localparam logic [SW-1:0] LAST_STEP = SW'(SEQ_LEN - 1);
  localparam logic [SW-1:0] LE_STEP   = SW'(SEQ_LEN - 2);
  localparam logic [CW-1:0] CAP_TOP   = CW'(CAP_MIN);

  logic [SW-1:0] step_q;
  logic [CW-1:0] low_q;
  pin_pair_t     cur;
  logic          hit, restart;

  always_comb begin
    cur     = '{oe_n: oe_n, le: le};
    hit     = (cur == seq_step(32'(step_q)));
    restart = (cur == seq_step(0));
  end

  // Mode-toggle sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q   <= '0;
      det_mode <= 1'b0;
    end else if (hit && step_q == LAST_STEP) begin
      step_q   <= '0;
      det_mode <= ~det_mode;
    end else if (hit) begin
      step_q   <= step_q + 1'b1;
    end else if (restart) begin
      step_q   <= SW'(1);
    end else begin
      step_q   <= '0;
    end
  end

  // Consecutive low-enable edge counter for capture cycles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= '0;
    end else if (!det_mode || oe_n) begin
      low_q <= '0;
    end else if (low_q != CAP_TOP) begin
      low_q <= low_q + 1'b1;
    end
  end

  assign le_block = (step_q == LE_STEP);
  assign cap_fire = det_mode & oe_n & (low_q == CAP_TOP);
  assign cap_snap = det_mode & ~oe_n;

endmodule

// File: rtl/lsd_shift_chain.sv
module lsd_shift_chain #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sdi,
  input  logic         clr,
  input  logic         load,
  input  logic [N-1:0] load_val,
  output logic [N-1:0] sr_q,
  output logic [N-1:0] sr_d
);
  logic [N-1:0] shifted;

  generate
    if (N == 1) begin : g_single
      assign shifted = sdi;
    end else begin : g_multi
      assign shifted = {sr_q[N-2:0], sdi};
    end
  endgenerate

  always_comb begin
    if (clr)       sr_d = '0;
    else if (load) sr_d = load_val;
    else           sr_d = shifted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

endmodule

// File: rtl/lsd_sink_stage.sv
module lsd_sink_stage #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lat_en,
  input  logic [N-1:0] sr_d,
  input  logic         oe_n,
  input  logic         tsd,
  input  logic         snap,
  input  logic [N-1:0] cmp_ok,
  output logic [N-1:0] lat_q,
  output logic [N-1:0] err_q,
  output logic [N-1:0] sink_on
);
  logic drive_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      err_q <= '0;
    end else begin
      if (lat_en) lat_q <= sr_d;
      if (snap)   err_q <= lat_q & cmp_ok;
    end
  end

  assign drive_en = ~oe_n & ~tsd;

  generate
    for (genvar g = 0; g < N; g++) begin : g_sink
      assign sink_on[g] = lat_q[g] & drive_en;
    end
  endgenerate

endmodule

// File: rtl/led_sink_ctl.sv
module led_sink_ctl #(
  parameter int N       = 16,
  parameter int CAP_MIN = 3
) (
  input  logic         clk,
  input  logic         pwr_ok,
  input  logic         sdi,
  input  logic         le,
  input  logic         oe_n,
  input  logic         tsd,
  input  logic [N-1:0] cmp_ok,
  output logic         sdo,
  output logic [N-1:0] sink_on
);
  logic         det_mode, le_block, cap_fire, cap_snap;
  logic [N-1:0] sr_q, sr_d, lat_q, err_q;

  lsd_mode_seq #(.CAP_MIN(CAP_MIN)) u_seq (
    .clk      (clk),
    .rst_n    (pwr_ok),
    .oe_n     (oe_n),
    .le       (le),
    .det_mode (det_mode),
    .le_block (le_block),
    .cap_fire (cap_fire),
    .cap_snap (cap_snap)
  );

  lsd_shift_chain #(.N(N)) u_chain (
    .clk      (clk),
    .rst_n    (pwr_ok),
    .sdi      (sdi),
    .clr      (det_mode & tsd),
    .load     (cap_fire),
    .load_val (err_q),
    .sr_q     (sr_q),
    .sr_d     (sr_d)
  );

  lsd_sink_stage #(.N(N)) u_sink (
    .clk     (clk),
    .rst_n   (pwr_ok),
    .lat_en  (le & ~le_block),
    .sr_d    (sr_d),
    .oe_n    (oe_n),
    .tsd     (tsd),
    .snap    (cap_snap),
    .cmp_ok  (cmp_ok),
    .lat_q   (lat_q),
    .err_q   (err_q),
    .sink_on (sink_on)
  );

  assign sdo = sr_q[N-1];

endmodule

// File: rtl/led_sink_ctl_chk.sv
module led_sink_ctl_chk #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         pwr_ok,
  input logic         sdi,
  input logic         le,
  input logic         oe_n,
  input logic         tsd,
  input logic [N-1:0] sink_on,
  input logic [N-1:0] lat_q,
  input logic [N-1:0] sr_q,
  input logic         det_mode,
  input logic         le_block
);
  // R1
  shift_in_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
    !det_mode |=> sr_q[0] == $past(sdi));

  // R2
  latch_hold_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
    !le |=> $stable(lat_q));

  // R2
  sink_subset_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
    (sink_on & ~lat_q) == '0);

  // R3
  blank_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
    oe_n |-> sink_on == '0);

  // R6
  seq_le_ignored_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
    le_block |=> $stable(lat_q));

  // R11
  hot_blank_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
    tsd |-> sink_on == '0);

  // R12
  hot_clear_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
    (det_mode && tsd) |=> sr_q == '0);

endmodule

bind led_sink_ctl led_sink_ctl_chk #(.N(N)) u_chk (
  .clk      (clk),
  .pwr_ok   (pwr_ok),
  .sdi      (sdi),
  .le       (le),
  .oe_n     (oe_n),
  .tsd      (tsd),
  .sink_on  (sink_on),
  .lat_q    (lat_q),
  .sr_q     (sr_q),
  .det_mode (det_mode),
  .le_block (le_block)
);

// File: tb/led_sink_ctl_bench.sv
module led_sink_ctl_bench;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         pwr_ok = 1'b0;
  logic         sdi = 1'b0, le = 1'b0, oe_n = 1'b0, tsd = 1'b0;
  logic [N-1:0] cmp_ok = '0;
  logic         sdo;
  logic [N-1:0] sink_on;
  int           n_cmp = 0, n_bad = 0;
  logic [N-1:0] got;

  // rows: {latched pattern, comparator flags, expected error word}
  localparam logic [3*N-1:0] DET_VEC [5] = '{
    {16'hFFFF, 16'hFFFF, 16'hFFFF},
    {16'hFFFF, 16'h0F0F, 16'h0F0F},
    {16'h0000, 16'hFFFF, 16'h0000},
    {16'hA5A5, 16'hFFFF, 16'hA5A5},
    {16'h3C3C, 16'h0FF0, 16'h0C30}
  };

  always #5 clk = ~clk;

  led_sink_ctl #(.N(N)) u_led_sink_ctl (
    .clk(clk), .pwr_ok(pwr_ok), .sdi(sdi), .le(le), .oe_n(oe_n),
    .tsd(tsd), .cmp_ok(cmp_ok), .sdo(sdo), .sink_on(sink_on)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input logic s, input logic o, input logic l);
    sdi = s; oe_n = o; le = l;
    @(posedge clk);
    @(negedge clk);
  endtask

  // Sends w MSB first; gathers what sdo showed before each edge.
  task automatic send(input logic [N-1:0] w, input logic o, input logic l_last,
                      output logic [N-1:0] old);
    for (int i = 0; i < N; i++) begin
      old[N-1-i] = sdo;
      tick(w[N-1-i], o, l_last && (i == N - 1));
    end
  endtask

  task automatic read_out(output logic [N-1:0] w);
    for (int i = 0; i < N; i++) begin
      w[N-1-i] = sdo;
      tick(1'b0, 1'b1, 1'b0);
    end
  endtask

  task automatic seq5(input logic s);
    tick(s, 1'b1, 1'b0);
    tick(s, 1'b0, 1'b0);
    tick(s, 1'b1, 1'b0);
    tick(s, 1'b1, 1'b1);
    tick(s, 1'b1, 1'b0);
  endtask

  // 0x1234 then four zero shifts; a capture would replace it.
  task automatic no_capture(input string req);
    send(16'h1234, 1'b1, 1'b0, got);
    repeat (3) tick(1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b1, 1'b0);
    read_out(got);
    chk(req, got, 16'h2340);
  endtask

  initial begin
    #100_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    pwr_ok = 1'b1;
    @(negedge clk);

    // R4 reset state
    chk("R4 sink after power-up", sink_on, '0);
    chk("R4 sdo after power-up", {15'b0, sdo}, '0);

    // R1 / R2 load and cascade
    send(16'hC3A5, 1'b0, 1'b1, got);
    chk("R2 latched word", sink_on, 16'hC3A5);
    send(16'h5A0F, 1'b0, 1'b1, got);
    chk("R1 cascade stream MSB first", got, 16'hC3A5);
    chk("R2 second latched word", sink_on, 16'h5A0F);
    tick(1'b1, 1'b0, 1'b0);
    chk("R2 hold while le low", sink_on, 16'h5A0F);
    tick(1'b0, 1'b0, 1'b1);
    chk("R2 follow with le high", sink_on, 16'h683E);
    tick(1'b1, 1'b0, 1'b1);
    chk("R2 follow next edge", sink_on, 16'hD07D);

    // R3 blanking
    tick(1'b0, 1'b1, 1'b0);
    chk("R3 blank with oe_n high", sink_on, '0);
    tick(1'b0, 1'b0, 1'b0);
    chk("R3 latch kept", sink_on, 16'hD07D);

    // R11 thermal blank in normal mode
    tsd = 1'b1;
    tick(1'b0, 1'b0, 1'b0);
    chk("R11 blank in shutdown", sink_on, '0);
    tsd = 1'b0;
    #1;
    chk("R11 data kept", sink_on, 16'hD07D);

    // R4 mid-run power loss
    @(negedge clk);
    pwr_ok = 1'b0;
    @(negedge clk);
    pwr_ok = 1'b1;
    @(negedge clk);
    chk("R4 latches cleared", sink_on, '0);

    // R5 broken sequence leaves normal mode
    tick(1'b0, 1'b1, 1'b0);
    tick(1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b1, 1'b0);
    tick(1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b1, 1'b1);
    tick(1'b0, 1'b1, 1'b0);
    cmp_ok = '1;
    no_capture("R5 broken sequence no capture");

    // R5 / R6 entry, latch unchanged by sequence
    send(16'h9F01, 1'b0, 1'b1, got);
    seq5(1'b1);
    tick(1'b0, 1'b0, 1'b0);
    chk("R6 latch untouched by entry", sink_on, 16'h9F01);
    tick(1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b1, 1'b0);
    read_out(got);
    chk("R7 R9 first capture readout", got, 16'h9F01);

    // R8 / R13 table of patterns in detection mode
    for (int r = 0; r < 5; r++) begin
      logic [N-1:0] pat, cmpv, errv;
      {pat, cmpv, errv} = DET_VEC[r];
      send(pat, 1'b1, 1'b1, got);
      cmp_ok = cmpv;
      tick(1'b0, 1'b0, 1'b0);
      chk("R13 new pattern latched in detection", sink_on, pat);
      tick(1'b0, 1'b0, 1'b0);
      tick(1'b0, 1'b0, 1'b0);
      tick(1'b0, 1'b1, 1'b0);
      read_out(got);
      chk("R8 error word", got, errv);
    end

    // R10 short low pulse aborts
    cmp_ok = '1;
    send(16'hBEEF, 1'b1, 1'b0, got);
    tick(1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b1, 1'b0);
    read_out(got);
    chk("R10 aborted capture", got, 16'hF778);

    // R12 shutdown clears register in detection mode
    send(16'hFFFF, 1'b1, 1'b0, got);
    tsd = 1'b1;
    tick(1'b1, 1'b0, 1'b0);
    chk("R11 blank in detection", sink_on, '0);
    tsd = 1'b0;
    tick(1'b0, 1'b1, 1'b0);
    read_out(got);
    chk("R12 register cleared", got, '0);

    // R5 exit back to normal mode
    seq5(1'b0);
    no_capture("R5 no capture after exit");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule